// File: doc/BRIEF.md
# Debug Trace Message Serializer

This block turns watchpoint-hit events into short debug trace messages and shifts them out over a narrow trace port: a 2-bit data bus and one framing pin, both driven from registers on the trace clock. Each hit is held in a small first-in first-out queue. The shifter then sends it as an 18-bit watchpoint message, low-order bits first, two bits per clock.

When a hit arrives and the queue is already full, the hit is thrown away. In its place the block raises a single pending error report, and once the queue has drained it sends this as a fixed 15-bit error message. The error message carries a code that means only watchpoint messages were lost. A ready input lets the trace port stall the shifter. A busy output tells the surrounding logic that a message is still queued, pending or being sent.

Top module: `trace_msg_serializer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the block empties its queue, clears any pending error report and, in the cycle after, shows `tr_data` = 2'b11, `tr_frame` = 1 and `busy` = 0.
- R2: Whenever no message is being sent, `tr_data` is 2'b11 and `tr_frame` is 1.
- R3: A watchpoint message is 18 bits wide. Bits [5:0] hold code 15, bits [9:6] hold source 4'b0000 and bits [17:10] hold the watchpoint number. It is sent over 9 consumed beats, and each beat carries the two lowest remaining bits, with the lower bit on `tr_data[0]`.
- R4: `tr_frame` is 0 on every beat of a message except the last, where it is 1.
- R5: Up to 4 accepted hits are held, and their messages leave in the order in which the hits arrived.
- R6: A hit that arrives when the queue held 4 entries at the start of the cycle, with no error report pending, is dropped and makes an error report pending. The error message is sent once every message accepted before it has been sent.
- R7: An error message is 15 bits wide. Bits [5:0] hold code 8, bits [9:6] hold source 4'b0000 and bits [14:10] hold error code 6 (watchpoint-only overrun). It is sent over 8 beats, and a 0 pad bit fills the top of the last beat.
- R8: A hit that arrives while an error report is pending is discarded, including in the cycle in which the error message is loaded. No second error message is produced for it.
- R9: When a message ends and another is queued or pending, the first beat of the next one appears in the very next consumed cycle, with no idle beat between them.
- R10: While `port_ready` is low, `tr_data` and `tr_frame` hold their values, no beat is consumed and no message starts. Hits are still accepted into the queue.
- R11: `busy` is 1 exactly when a message is being sent, the queue is not empty, or an error report is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Watchpoint-hit strobe, one hit per cycle |
| hit_num | input | NUM_W (8) | Number of the watchpoint that hit |
| port_ready | input | 1 | Trace port can take a beat this cycle |
| tr_data | output | 2 | Trace data bits, lowest message bit on bit 0 |
| tr_frame | output | 1 | Framing pin: 0 inside a message, 1 on its last beat and when idle |
| busy | output | 1 | Message in flight, queued or pending |

## Verification
The assertions take for granted that `hit_valid` carries at most one hit per cycle and that `port_ready` is a plain level that may change on any cycle. They also assume that reset is held from time zero until the first edge. The stimulus keeps to this: it drives every input right after the falling edge, holds reset high from time zero, and mixes random hit strobes and random ready stalls with directed bursts. The directed bursts fill the queue, force an overrun with further hits during the pending report, and stall the port in the middle of a message.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int CODE_W  = 6;
    localparam int SRC_W   = 4;
    localparam int ECODE_W = 5;
    localparam int ERR_W   = CODE_W + SRC_W + ECODE_W;

    localparam logic [CODE_W-1:0]  WP_MSG_CODE  = 6'd15;
    localparam logic [CODE_W-1:0]  ERR_MSG_CODE = 6'd8;
    localparam logic [ECODE_W-1:0] ECODE_WP_OVR = 5'd6;
    localparam logic [SRC_W-1:0]   SRC_ID       = 4'd0;
    localparam logic [1:0]         IDLE_DATA    = 2'b11;
endpackage

// File: rtl/trc_wp_queue.sv
module trc_wp_queue #(
    parameter int DEPTH = 4,
    parameter int NUM_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [NUM_W-1:0] hit_num,
    input  logic             pop,
    input  logic             err_take,
    output logic             head_valid,
    output logic [NUM_W-1:0] head_num,
    output logic             err_pend,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][NUM_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
        logic                        err;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     full;
    logic     push_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        push_ok = hit_valid && !full && !st_q.err;

        if (pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        if (push_ok) begin
            st_d.mem[st_q.wr] = hit_num;
            st_d.wr           = ptr_next(st_q.wr);
        end
        case ({push_ok, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (err_take) begin
            st_d.err = 1'b0;
        end
        if (hit_valid && full && !st_q.err) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_num   = st_q.mem[st_q.rd];
    assign err_pend   = st_q.err;
    assign count      = st_q.cnt;
endmodule

// File: rtl/trc_shifter.sv
module trc_shifter
    import trc_pkg::*;
#(
    parameter int NUM_W = 8,
    localparam int MSG_W     = CODE_W + SRC_W + NUM_W,
    localparam int WP_BEATS  = (MSG_W + 1) / 2,
    localparam int ERR_BEATS = (ERR_W + 1) / 2,
    localparam int BEAT_W    = $clog2(WP_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_ready,
    input  logic             head_valid,
    input  logic [NUM_W-1:0] head_num,
    input  logic             err_pend,
    output logic             pop,
    output logic             err_take,
    output logic [1:0]       tr_data,
    output logic             tr_frame,
    output logic             active,
    output logic             last_beat
);
    typedef struct packed {
        logic              act;
        logic [BEAT_W-1:0] beats;
        logic [MSG_W-1:0]  sh;
    } s_state_t;

    s_state_t st_d, st_q;
    logic     slot_free;

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        err_take  = 1'b0;
        slot_free = !st_q.act || (st_q.beats == BEAT_W'(1));

        if (port_ready) begin
            if (st_q.act && (st_q.beats != BEAT_W'(1))) begin
                st_d.sh    = st_q.sh >> 2;
                st_d.beats = st_q.beats - 1'b1;
            end
            if (slot_free) begin
                if (head_valid) begin
                    pop        = 1'b1;
                    st_d.act   = 1'b1;
                    st_d.beats = BEAT_W'(WP_BEATS);
                    st_d.sh    = {head_num, SRC_ID, WP_MSG_CODE};
                end else if (err_pend) begin
                    err_take   = 1'b1;
                    st_d.act   = 1'b1;
                    st_d.beats = BEAT_W'(ERR_BEATS);
                    st_d.sh    = MSG_W'({ECODE_WP_OVR, SRC_ID, ERR_MSG_CODE});
                end else begin
                    st_d.act   = 1'b0;
                    st_d.beats = '0;
                    st_d.sh    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_beat = st_q.act && (st_q.beats == BEAT_W'(1));
    assign active    = st_q.act;
    assign tr_data   = st_q.act ? st_q.sh[1:0] : IDLE_DATA;
    assign tr_frame  = st_q.act ? last_beat : 1'b1;
endmodule

// File: rtl/trace_msg_serializer.sv
module trace_msg_serializer #(
    parameter int DEPTH = 4,
    parameter int NUM_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [NUM_W-1:0] hit_num,
    input  logic             port_ready,
    output logic [1:0]       tr_data,
    output logic             tr_frame,
    output logic             busy
);
    logic             head_valid;
    logic [NUM_W-1:0] head_num;
    logic             err_pend;
    logic [CNT_W-1:0] q_count;
    logic             pop;
    logic             err_take;
    logic             ser_act;
    logic             ser_last;

    trc_wp_queue #(.DEPTH(DEPTH), .NUM_W(NUM_W)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .hit_valid  (hit_valid),
        .hit_num    (hit_num),
        .pop        (pop),
        .err_take   (err_take),
        .head_valid (head_valid),
        .head_num   (head_num),
        .err_pend   (err_pend),
        .count      (q_count)
    );

    trc_shifter #(.NUM_W(NUM_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .port_ready (port_ready),
        .head_valid (head_valid),
        .head_num   (head_num),
        .err_pend   (err_pend),
        .pop        (pop),
        .err_take   (err_take),
        .tr_data    (tr_data),
        .tr_frame   (tr_frame),
        .active     (ser_act),
        .last_beat  (ser_last)
    );

    assign busy = ser_act || head_valid || err_pend;
endmodule

// File: rtl/trc_serializer_chk.sv
module trc_serializer_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_valid,
    input logic             port_ready,
    input logic [1:0]       tr_data,
    input logic             tr_frame,
    input logic             busy,
    input logic [CNT_W-1:0] q_count,
    input logic             err_pend,
    input logic             ser_act,
    input logic             ser_last
);
    p_idle_pattern_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tr_data == 2'b11) && tr_frame);

    p_frame_low_mid_r4: assert property (@(posedge clk) disable iff (rst)
        (ser_act && !ser_last) |-> !tr_frame);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_overflow_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && (q_count == CNT_W'(DEPTH)) && !err_pend) |=> err_pend);

    p_no_push_while_err_r8: assert property (@(posedge clk) disable iff (rst)
        (err_pend && hit_valid) |=> q_count <= $past(q_count));

    p_gapless_r9: assert property (@(posedge clk) disable iff (rst)
        (ser_last && port_ready && (q_count != '0)) |=> ser_act && !tr_frame);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !port_ready |=> $stable(tr_data) && $stable(tr_frame));

    p_busy_level_r11: assert property (@(posedge clk) disable iff (rst)
        (q_count != '0) |-> busy);
endmodule

bind trace_msg_serializer trc_serializer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hit_valid  (hit_valid),
    .port_ready (port_ready),
    .tr_data    (tr_data),
    .tr_frame   (tr_frame),
    .busy       (busy),
    .q_count    (q_count),
    .err_pend   (err_pend),
    .ser_act    (ser_act),
    .ser_last   (ser_last)
);

// File: tb/tb_trace_msg_serializer.sv
module tb_trace_msg_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_valid = 1'b0;
    logic [7:0] hit_num = 8'h00;
    logic       port_ready = 1'b1;
    logic [1:0] tr_data;
    logic       tr_frame;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // reference model state
    bit          m_act;
    int          m_beats;
    bit [17:0]   m_sh;
    int          m_fifo[$];
    bit          m_err;

    // stream monitor
    bit          mon_in;
    int          mon_k;
    int          mon_idle;
    int          mon_n;
    int unsigned mon_acc;
    int unsigned mon_word[64];
    int          mon_beats[64];
    int          mon_gap[64];

    always #2.5 clk = ~clk;

    trace_msg_serializer dut (
        .clk        (clk),
        .rst        (rst),
        .hit_valid  (hit_valid),
        .hit_num    (hit_num),
        .port_ready (port_ready),
        .tr_data    (tr_data),
        .tr_frame   (tr_frame),
        .busy       (busy)
    );

    function automatic int unsigned wp_word(input int n);
        return (int'(n) << 10) | 15;
    endfunction

    function automatic int unsigned err_word();
        return (6 << 10) | 8;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        mon_in = 0; mon_k = 0; mon_idle = 0; mon_n = 0; mon_acc = 0;
    endtask

    task automatic model_reset();
        m_act = 0; m_beats = 0; m_sh = '0; m_err = 0;
        m_fifo.delete();
    endtask

    task automatic model_step(input bit hv, input int hn, input bit rdy);
        int  old_cnt;
        bit  old_err;
        bit  slot;
        old_cnt = m_fifo.size();
        old_err = m_err;
        slot    = !m_act || (m_beats == 1);
        if (rdy) begin
            if (m_act && m_beats != 1) begin
                m_sh = m_sh >> 2;
                m_beats--;
            end
            if (slot) begin
                if (old_cnt > 0) begin
                    m_sh = 18'(wp_word(m_fifo.pop_front()));
                    m_act = 1; m_beats = 9;
                end else if (m_err) begin
                    m_sh = 18'(err_word());
                    m_err = 0; m_act = 1; m_beats = 8;
                end else begin
                    m_act = 0; m_beats = 0;
                end
            end
        end
        if (hv) begin
            if (old_cnt == 4) begin
                if (!old_err) m_err = 1;
            end else if (!old_err) begin
                m_fifo.push_back(hn);
            end
        end
    endtask

    task automatic compare_all();
        int  ed;
        int  ef;
        int  eb;
        ed = m_act ? int'(m_sh[1:0]) : 3;
        ef = m_act ? int'(m_beats == 1) : 1;
        eb = int'(m_act || m_fifo.size() != 0 || m_err);
        if (!m_act) begin
            check("R2 idle data", int'(tr_data), ed);
            check("R2 idle frame", int'(tr_frame), ef);
        end else begin
            check("R3 beat data", int'(tr_data), ed);
            check("R4 frame", int'(tr_frame), ef);
        end
        check("R11 busy", int'(busy), eb);
    endtask

    // one cycle: called just after a falling edge
    task automatic cyc(input bit hv, input int hn, input bit rdy);
        hit_valid  = hv;
        hit_num    = 8'(hn);
        port_ready = rdy;
        if (rdy) begin
            if (!mon_in) begin
                if (tr_frame == 1'b0) begin
                    mon_in = 1; mon_k = 0; mon_acc = 0;
                    if (mon_n < 64) mon_gap[mon_n] = mon_idle;
                end else begin
                    mon_idle++;
                end
            end
            if (mon_in) begin
                mon_acc = mon_acc | (int'(tr_data) << (2 * mon_k));
                mon_k++;
                if (tr_frame) begin
                    if (mon_n < 64) begin
                        mon_word[mon_n]  = mon_acc;
                        mon_beats[mon_n] = mon_k;
                        mon_n++;
                    end
                    mon_in = 0; mon_idle = 0;
                end
            end
        end
        @(posedge clk);
        model_step(hv, hn, rdy);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1; hit_valid = 1'b0; port_ready = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        mon_clear();
        check("R1 reset data", int'(tr_data), 3);
        check("R1 reset frame", int'(tr_frame), 1);
        check("R1 reset busy", int'(busy), 0);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1);
    endtask

    initial begin
        logic [1:0] hold_d;
        logic       hold_f;
        int         seen_err;
        do_reset();

        // single watchpoint message
        cyc(1, 8'hA5, 1);
        check("R11 busy after hit", int'(busy), 1);
        idle(14);
        check("R3 message count", mon_n, 1);
        check("R3 watchpoint word", int'(mon_word[0]), int'(wp_word(8'hA5)));
        check("R3 beat count", mon_beats[0], 9);

        // burst that overruns the queue
        mon_clear();
        for (int i = 1; i <= 7; i++) cyc(1, i, 1);
        idle(80);
        check("R6 messages incl. error", mon_n, 6);
        for (int i = 0; i < 5; i++)
            check("R5 fifo order", int'(mon_word[i]), int'(wp_word(i + 1)));
        check("R7 error word", int'(mon_word[5]), int'(err_word()));
        check("R7 error beats", mon_beats[5], 8);
        check("R9 no gap", mon_gap[1], 0);
        check("R9 no gap before error", mon_gap[5], 0);
        seen_err = 0;
        for (int i = 0; i < mon_n; i++) if (mon_word[i] == err_word()) seen_err++;
        check("R8 single error", seen_err, 1);
        check("R11 idle busy", int'(busy), 0);

        // hits while error pending: fill, overrun, then more hits until drained
        mon_clear();
        for (int i = 0; i < 6; i++) cyc(1, 8'h40 + i, 1);
        for (int i = 0; i < 30; i++) cyc(1, 8'h80, 1);
        idle(60);
        seen_err = 0;
        for (int i = 0; i < mon_n; i++) if (mon_word[i] == err_word()) seen_err++;
        check("R8 one error for many drops", seen_err, 1);

        // stall in mid message
        mon_clear();
        cyc(1, 8'h3C, 1);
        idle(3);
        hold_d = tr_data; hold_f = tr_frame;
        for (int i = 0; i < 5; i++) begin
            cyc((i == 2), 8'h11, 0);
            check("R10 data held", int'(tr_data), int'(hold_d));
            check("R10 frame held", int'(tr_frame), int'(hold_f));
        end
        idle(25);
        check("R10 word after stall", int'(mon_word[0]), int'(wp_word(8'h3C)));
        check("R10 hit during stall kept", int'(mon_word[1]), int'(wp_word(8'h11)));

        // idle with ready low: nothing starts
        cyc(1, 8'h22, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0);
            check("R10 no start while stalled", int'(tr_data), 3);
        end
        idle(15);

        // reset in mid traffic
        cyc(1, 8'h55, 1);
        cyc(1, 8'h56, 1);
        do_reset();

        // random traffic
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) == 0, $urandom % 256, ($urandom % 8) != 0);
        end
        idle(120);
        check("R11 drained busy", int'(busy), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc_cnt, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule